// File: doc/BRIEF.md
# Interrupt Status Register with Force-Event Alias

This block holds a 32-bit interrupt status word. A hardware event pulse on a bit sets that bit, provided its status-enable bit is on. Software clears a bit by writing a 1 to it at the status offset. Software can also set bits on purpose, to test interrupt handling, through a separate force offset. The force offset has no storage of its own: a write there acts directly on the status word. Reads from it always return zero.

A forced bit takes effect only when three things hold: the bit was written as 1, its status-enable bit is on, and the bus-clock keepalive input is high in the cycle the write is applied. A separate signal-enable mask selects which status bits drive the single interrupt line. That line is registered.

The register port is a plain strobe bus with `wr_en`, `rd_en`, a 2-bit word offset and 32-bit data. A small phase machine latches each access. It has three states:
- `PH_IDLE`: no access is pending.
- `PH_WRITE`: a write is applied.
- `PH_READ`: read data is registered.

The transitions are as follows. From any state, the machine goes to `PH_WRITE` when `wr_en` is high. Otherwise it goes to `PH_READ` when `rd_en` is high. Otherwise it returns to `PH_IDLE`. The register offsets are status = 0, status-enable = 1, signal-enable = 2 and force = 3.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the status, status-enable and signal-enable registers are zero. `irq` is low. Reads of all four offsets return zero.
- R2: A high bit on `hw_evt` sets the matching status bit at the next clock edge only when its status-enable bit is 1. With the enable at 0, the bit stays 0.
- R3: Writing to offset 0 clears every status bit written as 1. Bits written as 0 keep their value.
- R4: When a hardware event sets a bit in the same cycle that a write to offset 0 clears it, the bit ends up set.
- R5: Writing to offset 3 with `clk_keepalive` high sets every status bit that is written as 1 and has its status-enable bit at 1.
- R6: At offset 3, bits written as 0, and bits whose status-enable bit is 0, leave the status word unchanged.
- R7: A write to offset 3 applied while `clk_keepalive` is low leaves the status word unchanged.
- R8: A read of offset 3 returns all zeros, whatever the status word holds.
- R9: `irq` equals the OR over all bits of (status AND signal-enable), delayed by one clock.
- R10: A request is latched at the first rising edge and applied at the second. For a read, `rd_valid` goes high for one cycle after the second edge, with `rd_data` valid in that cycle.
- R11: Offsets 1 and 2 read back the last values written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request strobe |
| rd_en | input | 1 | Read request strobe |
| addr | input | 2 | Word offset: 0 status, 1 status-enable, 2 signal-enable, 3 force |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data |
| rd_valid | output | 1 | One-cycle read-data qualifier |
| hw_evt | input | 32 | Hardware event pulses, one per status bit |
| clk_keepalive | input | 1 | Bus-clock keepalive; must be high for forced sets to land |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a clear and a hardware set landing on one bit in the same clock. The clear is applied one cycle after its request, so the stimulus raises the event exactly one cycle after the write strobe. The status word is then read back to show that the set won. The force path is exercised against three gates, one at a time: a disabled bit, a zero data bit, and a dropped keepalive. After each forced write, a readback shows whether the status word changed.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int unsigned OFS_W = 2;

    typedef enum logic [OFS_W-1:0] {
        OFS_STATUS  = 2'd0,
        OFS_STAT_EN = 2'd1,
        OFS_SIG_EN  = 2'd2,
        OFS_FORCE   = 2'd3
    } reg_ofs_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } bus_phase_e;

endpackage

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_stat_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [OFS_W-1:0]     addr,
    input  logic [DW-1:0]        wdata,
    output bus_phase_e           phase,
    output reg_ofs_e             cap_addr,
    output logic [DW-1:0]        cap_data,
    output logic                 wr_status,
    output logic                 wr_sten,
    output logic                 wr_sig,
    output logic                 wr_force,
    output logic                 rd_fire
);

    bus_phase_e phase_q, phase_d;

    // next-state selection: write has priority over read
    always_comb begin
        if (wr_en)      phase_d = PH_WRITE;
        else if (rd_en) phase_d = PH_READ;
        else            phase_d = PH_IDLE;
    end

    // state register together with the captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            cap_addr <= OFS_STATUS;
            cap_data <= '0;
        end else begin
            phase_q <= phase_d;
            if (wr_en || rd_en) begin
                cap_addr <= reg_ofs_e'(addr);
                cap_data <= wdata;
            end
        end
    end

    // output decode per state
    always_comb begin
        wr_status = 1'b0;
        wr_sten   = 1'b0;
        wr_sig    = 1'b0;
        wr_force  = 1'b0;
        rd_fire   = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
            end
            PH_WRITE: begin
                unique case (cap_addr)
                    OFS_STATUS:  wr_status = 1'b1;
                    OFS_STAT_EN: wr_sten   = 1'b1;
                    OFS_SIG_EN:  wr_sig    = 1'b1;
                    OFS_FORCE:   wr_force  = 1'b1;
                endcase
            end
            PH_READ: begin
                rd_fire = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign phase = phase_q;

endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits #(
    parameter int unsigned NB = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] evt,
    input  logic [NB-1:0] sten,
    input  logic [NB-1:0] clr_mask,
    input  logic [NB-1:0] force_mask,
    output logic [NB-1:0] status
);

    for (genvar i = 0; i < NB; i++) begin : g_bit
        logic set_i;
        logic bit_q;

        // a set from either source outranks a clear in the same cycle
        assign set_i = sten[i] & (evt[i] | force_mask[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           bit_q <= 1'b0;
            else if (set_i)       bit_q <= 1'b1;
            else if (clr_mask[i]) bit_q <= 1'b0;
        end

        assign status[i] = bit_q;
    end

endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
    parameter int unsigned NB = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] status,
    input  logic [NB-1:0] sig_en,
    output logic          irq
);

    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status & sig_en);
    end

    assign irq = irq_q;

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_stat_pkg::*;
#(
    parameter int unsigned NB = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OFS_W-1:0]  addr,
    input  logic [NB-1:0]     wdata,
    output logic [NB-1:0]     rd_data,
    output logic              rd_valid,
    input  logic [NB-1:0]     hw_evt,
    input  logic              clk_keepalive,
    output logic              irq
);

    bus_phase_e      phase;
    reg_ofs_e        cap_addr;
    logic [NB-1:0]   cap_data;
    logic            wr_status, wr_sten, wr_sig, wr_force, rd_fire;
    logic [NB-1:0]   sten_q, sig_q, status_q;
    logic [NB-1:0]   clr_mask, force_mask, rd_mux;

    irq_bus_fsm #(.DW(NB)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .phase     (phase),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data),
        .wr_status (wr_status),
        .wr_sten   (wr_sten),
        .wr_sig    (wr_sig),
        .wr_force  (wr_force),
        .rd_fire   (rd_fire)
    );

    // enable masks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sten_q <= '0;
            sig_q  <= '0;
        end else begin
            if (wr_sten) sten_q <= cap_data;
            if (wr_sig)  sig_q  <= cap_data;
        end
    end

    assign clr_mask   = wr_status ? cap_data : '0;
    assign force_mask = (wr_force && clk_keepalive) ? cap_data : '0;

    irq_status_bits #(.NB(NB)) u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (hw_evt),
        .sten       (sten_q),
        .clr_mask   (clr_mask),
        .force_mask (force_mask),
        .status     (status_q)
    );

    irq_combine #(.NB(NB)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status_q),
        .sig_en (sig_q),
        .irq    (irq)
    );

    // read selection; the force alias has no storage and reads as zero
    always_comb begin
        unique case (cap_addr)
            OFS_STATUS:  rd_mux = status_q;
            OFS_STAT_EN: rd_mux = sten_q;
            OFS_SIG_EN:  rd_mux = sig_q;
            OFS_FORCE:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire) rd_data <= rd_mux;
        end
    end

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_stat_pkg::*;
#(
    parameter int unsigned NB = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_phase_e    phase,
    input  reg_ofs_e      cap_addr,
    input  logic [NB-1:0] cap_data,
    input  logic          clk_keepalive,
    input  logic [NB-1:0] hw_evt,
    input  logic [NB-1:0] sten_q,
    input  logic [NB-1:0] sig_q,
    input  logic [NB-1:0] status_q,
    input  logic          rd_valid,
    input  logic [NB-1:0] rd_data,
    input  logic          irq
);

    // R2: a newly set bit must have had its status-enable on
    a_r2_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q) & ~$past(sten_q)) == '0));

    // R3: a clear with no competing event empties the written bits
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE && cap_addr == OFS_STATUS && hw_evt == '0)
        |=> ((status_q & $past(cap_data)) == '0));

    // R4: an enabled event survives a same-cycle clear
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE && cap_addr == OFS_STATUS)
        |=> ((status_q & $past(hw_evt & sten_q)) == $past(hw_evt & sten_q)));

    // R7: no forced change while keepalive is low
    a_r7_keepalive_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE && cap_addr == OFS_FORCE && !clk_keepalive && hw_evt == '0)
        |=> $stable(status_q));

    // R8: alias reads as zero
    a_r8_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READ && cap_addr == OFS_FORCE) |=> (rd_valid && rd_data == '0));

    // R9: interrupt line tracks masked status one cycle later
    a_r9_irq_delayed: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(status_q) & $past(sig_q))));

endmodule

bind irq_status_ctrl irq_status_chk #(.NB(NB)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .phase         (phase),
    .cap_addr      (cap_addr),
    .cap_data      (cap_data),
    .clk_keepalive (clk_keepalive),
    .hw_evt        (hw_evt),
    .sten_q        (sten_q),
    .sig_q         (sig_q),
    .status_q      (status_q),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .irq           (irq)
);

// File: tb/tb_irq_status_ctrl.sv
`timescale 1ns/1ps
module tb_irq_status_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [31:0] hw_evt = '0;
    logic        clk_keepalive = 1'b1;
    logic        irq;

    int total = 0;
    int bad = 0;

    logic [31:0] m_stat = '0, m_sten = '0, m_sig = '0;

    typedef struct {
        string       req;
        logic [31:0] exp;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    irq_status_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid), .hw_evt(hw_evt),
        .clk_keepalive(clk_keepalive), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb_q.size() == 0) chk("R10 unexpected rd_valid", 32'd1, 32'd0);
            else begin
                sb_item_t it;
                it = sb_q.pop_front();
                chk(it.req, rd_data, it.exp);
            end
        end
    end

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        case (a)
            2'd0: m_stat = m_stat & ~d;
            2'd1: m_sten = d;
            2'd2: m_sig  = d;
            default: if (clk_keepalive) m_stat = m_stat | (d & m_sten);
        endcase
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [31:0] exp, input string req);
        sb_item_t it;
        it.req = req; it.exp = exp;
        sb_q.push_back(it);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_evt(input logic [31:0] m);
        @(negedge clk); hw_evt = m;
        @(negedge clk); hw_evt = '0;
        m_stat = m_stat | (m & m_sten);
    endtask

    task automatic chk_irq(input string req);
        @(negedge clk); @(negedge clk);
        chk(req, {31'd0, irq}, {31'd0, |(m_stat & m_sig)});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        bus_rd(2'd0, 32'd0, "R1 status reset");
        bus_rd(2'd1, 32'd0, "R1 status-enable reset");
        bus_rd(2'd2, 32'd0, "R1 signal-enable reset");
        bus_rd(2'd3, 32'd0, "R1 force alias reset");

        // R11: enable registers read back
        bus_wr(2'd1, 32'h0000_FFFF);
        bus_wr(2'd2, 32'h0000_00F0);
        bus_rd(2'd1, 32'h0000_FFFF, "R11 status-enable readback");
        bus_rd(2'd2, 32'h0000_00F0, "R11 signal-enable readback");

        // R10: read timing
        @(negedge clk); rd_en = 1'b1; addr = 2'd1;
        sb_q.push_back('{req: "R10 timed read", exp: 32'h0000_FFFF});
        @(negedge clk); rd_en = 1'b0;
        chk("R10 rd_valid low after first edge", {31'd0, rd_valid}, 32'd0);
        @(negedge clk);
        chk("R10 rd_valid high after second edge", {31'd0, rd_valid}, 32'd1);
        @(negedge clk);
        chk("R10 rd_valid one cycle", {31'd0, rd_valid}, 32'd0);

        // R2: hardware events, bit 16 disabled
        pulse_evt(32'h0001_0003);
        bus_rd(2'd0, 32'h0000_0003, "R2 event sets enabled bits only");
        chk_irq("R9 irq low with unmasked status");
        pulse_evt(32'h0000_0010);
        chk_irq("R9 irq high on masked status");
        chk("R9 irq value", {31'd0, irq}, 32'd1);

        // R3: write-1-to-clear
        bus_wr(2'd0, 32'h0000_0002);
        bus_rd(2'd0, 32'h0000_0011, "R3 clear one bit keep others");
        bus_wr(2'd0, 32'h0000_0010);
        chk_irq("R9 irq drops after clear");
        bus_rd(2'd0, 32'h0000_0001, "R3 second clear");

        // R4: clear and event on bit 0 in the same applied cycle
        @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 32'h0000_0001;
        @(negedge clk); wr_en = 1'b0; hw_evt = 32'h0000_0001;
        @(negedge clk); hw_evt = '0;
        bus_rd(2'd0, 32'h0000_0001, "R4 set wins over clear");

        // R5 / R8: forced sets with keepalive high
        bus_wr(2'd3, 32'h0000_0300);
        bus_rd(2'd0, 32'h0000_0301, "R5 force sets enabled bits");
        bus_rd(2'd3, 32'h0000_0000, "R8 alias reads zero with status set");

        // R6: disabled bit and zero data
        bus_wr(2'd3, 32'h0001_0000);
        bus_rd(2'd0, 32'h0000_0301, "R6 force on disabled bit ignored");
        bus_wr(2'd3, 32'h0000_0000);
        bus_rd(2'd0, 32'h0000_0301, "R6 force of zeros ignored");

        // R7: keepalive low blocks forcing
        clk_keepalive = 1'b0;
        bus_wr(2'd3, 32'h0000_4000);
        bus_rd(2'd0, 32'h0000_0301, "R7 force blocked without keepalive");
        clk_keepalive = 1'b1;
        bus_wr(2'd3, 32'h0000_4000);
        bus_rd(2'd0, 32'h0000_4301, "R7 force lands with keepalive");

        // R5 / R9: force drives the interrupt line
        bus_wr(2'd3, 32'h0000_0020);
        chk_irq("R9 irq from forced bit");
        bus_rd(2'd0, m_stat, "R5 forced bit visible");

        repeat (3) @(negedge clk);
        chk("R10 scoreboard drained", sb_q.size(), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule